// File: doc/BRIEF.md
# Seven-Point Stencil Matrix-Vector Engine

This engine computes one pass of a sparse matrix-vector product for a structured 3-D mesh whose cells are stored column by column. One core's share of the mesh is a single column of cells. For each cell the engine forms seven terms and adds them. The seven terms take the cell's own value, the values directly above and below it in the same column, and the values at the same index in four adjacent columns, and multiply each one by a coefficient that belongs to that cell. The engine writes one 32-bit result per cell to a result port.

The engine reads the column from a local vector memory through one read port. It builds the above and below operands by sliding a window along that stream, so it does not read the column three times. At both ends of the column, a boundary value takes the place of the missing neighbour. The four neighbour-column memories and the coefficient memory share a second address. All memories are synchronous, and their read data is valid on the cycle after the address.

After the pipeline fills, the engine produces one cell per cycle with no stalls. A done pulse marks the end of each pass.

Top module: `stencil_spmv`

## Requirements
- R1: The column length is the parameter CELLS (default 1500). A pass writes exactly CELLS results at addresses 0, 1, …, CELLS-1. The addresses rise by one and are written on consecutive cycles with no gap.
- R2: The result for cell i is the sum of seven signed 16×16 products. The 112-bit coefficient word for cell i holds seven signed 16-bit fields, and field j sits at bits [16j+15:16j]. The fields are ordered 0 = centre (local x[i]), 1 = up, 2 = down, 3 = north, 4 = south, 5 = east, 6 = west.
- R3: The up operand of cell i is x[i+1]. For cell CELLS-1 it is bnd_val, not a wrapped element.
- R4: The down operand of cell i is x[i-1]. For cell 0 it is bnd_val.
- R5: The north, south, east and west operands of cell i are the words that nb_n, nb_s, nb_e and nb_w return for cell_addr = i.
- R6: The sum is formed exactly and then clamped to the signed 32-bit range. Values above 2147483647 give 2147483647, and values below -2147483648 give -2147483648.
- R7: If start is sampled high at clock edge S while the engine is idle, the write for cell i is visible after edge S+4+i. Memory read data must be valid one cycle after the read address.
- R8: done is a one-cycle pulse, visible on the cycle right after the write of cell CELLS-1. It is never high together with res_we.
- R9: While a pass is still issuing reads, start has no effect. The engine accepts start again CELLS+2 edges after the last acceptance, so holding start high runs passes back to back at that spacing.
- R10: While reset is asserted and after it is released, with no start, res_we and done stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when the engine is idle |
| bnd_val | input | 16 | Boundary value inserted at both column ends; held stable during a pass |
| loc_re | output | 1 | Local vector memory read enable |
| loc_addr | output | clog2(CELLS) | Local vector memory read address |
| loc_rdata | input | 16 | Local vector read data, one cycle after the address |
| cell_re | output | 1 | Read enable shared by the neighbour and coefficient memories |
| cell_addr | output | clog2(CELLS) | Cell index for the neighbour and coefficient memories |
| nb_n | input | 16 | North neighbour-column value |
| nb_s | input | 16 | South neighbour-column value |
| nb_e | input | 16 | East neighbour-column value |
| nb_w | input | 16 | West neighbour-column value |
| coef_rdata | input | 112 | Seven packed coefficients for the cell |
| res_we | output | 1 | Result write strobe |
| res_addr | output | clog2(CELLS) | Result cell index |
| res_data | output | 32 | Saturated result |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two activities can overlap in time. One is a new pass being accepted and its reads starting. The other is the previous pass's results draining through the pipeline, ending with its done pulse. The bench provokes this overlap by holding start high across two passes, so that the second acceptance falls while the first pass's last writes and done are still in flight.

A scoreboard then checks three things:
- the results arrive in strict order, with the second pass's first write exactly four edges after its acceptance;
- done appears exactly once per pass, on the cycle after the last write;
- done never appears together with a write.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int DW    = 16;   // operand and coefficient width
  localparam int ACCW  = 32;   // result width
  localparam int TAPS  = 7;    // stencil points per cell
  localparam int CFW   = TAPS * DW;
  // tap order inside the coefficient word and the operand bus
  localparam int TAP_C  = 0;
  localparam int TAP_UP = 1;
  localparam int TAP_DN = 2;
  localparam int TAP_N  = 3;
  localparam int TAP_S  = 4;
  localparam int TAP_E  = 5;
  localparam int TAP_W  = 6;
  typedef logic signed [DW-1:0]   opnd_t;
  typedef logic signed [ACCW-1:0] prod_t;
endpackage

// File: rtl/stencil_seq.sv
module stencil_seq #(
  parameter int CELLS = 1500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     loc_re,
  output logic [$clog2(CELLS)-1:0] loc_addr,
  output logic                     cell_re,
  output logic [$clog2(CELLS)-1:0] cell_addr,
  output logic                     s1_load,
  output logic                     s1_first,
  output logic                     s1_cell,
  output logic                     s1_last,
  output logic [$clog2(CELLS)-1:0] s1_idx
);
  localparam int AW = $clog2(CELLS);
  localparam int KW = $clog2(CELLS + 1);
  localparam logic [KW-1:0] KLAST = KW'(CELLS);

  logic          run_q, run_n;
  logic [KW-1:0] k_q, k_n;

  always_comb begin
    run_n = run_q;
    k_n   = k_q;
    if (run_q) begin
      if (k_q == KLAST) run_n = 1'b0;
      else              k_n   = k_q + 1'b1;
    end else if (start) begin
      run_n = 1'b1;
      k_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      k_q   <= '0;
    end else begin
      run_q <= run_n;
      k_q   <= k_n;
    end
  end

  assign loc_re    = run_q && (k_q != KLAST);
  assign loc_addr  = AW'(k_q);
  assign cell_re   = run_q && (k_q != '0);
  assign cell_addr = AW'(k_q - 1'b1);

  // stage-1 tags travel alongside the memory read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_load  <= 1'b0;
      s1_first <= 1'b0;
      s1_cell  <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_load  <= loc_re;
      s1_first <= run_q && (k_q == '0);
      s1_cell  <= cell_re;
      s1_last  <= run_q && (k_q == KLAST);
      s1_idx   <= cell_addr;
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (k_q != KLAST) && start) |=> (run_q && (k_q == $past(k_q) + 1'b1)));

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_re |-> (int'(loc_addr) < CELLS));
endmodule

// File: rtl/stencil_win.sv
module stencil_win
  import stencil_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  opnd_t bnd,
  input  logic  s1_load,
  input  logic  s1_first,
  input  logic  s1_last,
  input  opnd_t loc_rdata,
  output opnd_t op_c,
  output opnd_t op_up,
  output opnd_t op_dn
);
  opnd_t w_c_q, w_c_n;
  opnd_t w_d_q, w_d_n;

  always_comb begin
    w_c_n = w_c_q;
    w_d_n = w_d_q;
    if (s1_load) begin
      w_c_n = loc_rdata;
      w_d_n = s1_first ? bnd : w_c_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_c_q <= '0;
      w_d_q <= '0;
    end else if (s1_load) begin
      w_c_q <= w_c_n;
      w_d_q <= w_d_n;
    end
  end

  assign op_c  = w_c_q;
  assign op_dn = w_d_q;
  assign op_up = s1_last ? bnd : loc_rdata;

  // R4
  first_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_load && s1_first) |=> (op_dn == $past(bnd)));
endmodule

// File: rtl/stencil_mac.sv
module stencil_mac
  import stencil_pkg::*;
#(
  parameter int CELLS = 1500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_cell,
  input  logic                     s1_last,
  input  logic [$clog2(CELLS)-1:0] s1_idx,
  input  logic [CFW-1:0]           op_bus,
  input  logic [CFW-1:0]           coef_bus,
  output logic                     res_we,
  output logic [$clog2(CELLS)-1:0] res_addr,
  output prod_t                    res_data,
  output logic                     done
);
  localparam int AW = $clog2(CELLS);
  localparam int SW = ACCW + $clog2(TAPS) + 1;
  localparam logic signed [SW-1:0] SMAX = {{(SW-ACCW+1){1'b0}}, {(ACCW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {{(SW-ACCW+1){1'b1}}, {(ACCW-1){1'b0}}};

  prod_t prod_n [TAPS];
  prod_t prod_q [TAPS];
  logic          v2_q, last2_q, res_last_q;
  logic [AW-1:0] idx2_q;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign prod_n[t] = prod_t'($signed(op_bus[t*DW +: DW])) *
                       prod_t'($signed(coef_bus[t*DW +: DW]));
  end

  always_ff @(posedge clk) begin
    if (s1_cell) begin
      for (int t = 0; t < TAPS; t++) prod_q[t] <= prod_n[t];
      idx2_q <= s1_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q    <= 1'b0;
      last2_q <= 1'b0;
    end else begin
      v2_q    <= s1_cell;
      last2_q <= s1_cell && s1_last;
    end
  end

  logic signed [SW-1:0] sum;
  prod_t                sat;

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) sum = sum + SW'(prod_q[t]);
    if (sum > SMAX)      sat = SMAX[ACCW-1:0];
    else if (sum < SMIN) sat = SMIN[ACCW-1:0];
    else                 sat = sum[ACCW-1:0];
  end

  always_ff @(posedge clk) begin
    if (v2_q) begin
      res_data <= sat;
      res_addr <= idx2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_we     <= 1'b0;
      res_last_q <= 1'b0;
      done       <= 1'b0;
    end else begin
      res_we     <= v2_q;
      res_last_q <= last2_q;
      done       <= res_we && res_last_q;
    end
  end

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (sum > SMAX)) |=> (res_data == SMAX[ACCW-1:0]));

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (sum < SMIN)) |=> (res_data == SMIN[ACCW-1:0]));

  // R1
  stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && !res_last_q) |=> (res_we && (res_addr == $past(res_addr) + 1'b1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !res_we);
endmodule

// File: rtl/stencil_spmv.sv
module stencil_spmv
  import stencil_pkg::*;
#(
  parameter int CELLS = 1500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DW-1:0]     bnd_val,
  output logic                     loc_re,
  output logic [$clog2(CELLS)-1:0] loc_addr,
  input  logic signed [DW-1:0]     loc_rdata,
  output logic                     cell_re,
  output logic [$clog2(CELLS)-1:0] cell_addr,
  input  logic signed [DW-1:0]     nb_n,
  input  logic signed [DW-1:0]     nb_s,
  input  logic signed [DW-1:0]     nb_e,
  input  logic signed [DW-1:0]     nb_w,
  input  logic [CFW-1:0]           coef_rdata,
  output logic                     res_we,
  output logic [$clog2(CELLS)-1:0] res_addr,
  output logic signed [ACCW-1:0]   res_data,
  output logic                     done
);
  localparam int AW = $clog2(CELLS);

  logic          s1_load, s1_first, s1_cell, s1_last;
  logic [AW-1:0] s1_idx;
  opnd_t         op_c, op_up, op_dn;
  logic [CFW-1:0] op_bus;

  stencil_seq #(.CELLS(CELLS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .loc_re   (loc_re),
    .loc_addr (loc_addr),
    .cell_re  (cell_re),
    .cell_addr(cell_addr),
    .s1_load  (s1_load),
    .s1_first (s1_first),
    .s1_cell  (s1_cell),
    .s1_last  (s1_last),
    .s1_idx   (s1_idx)
  );

  stencil_win u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .bnd      (bnd_val),
    .s1_load  (s1_load),
    .s1_first (s1_first),
    .s1_last  (s1_last),
    .loc_rdata(loc_rdata),
    .op_c     (op_c),
    .op_up    (op_up),
    .op_dn    (op_dn)
  );

  always_comb begin
    op_bus = '0;
    op_bus[TAP_C*DW  +: DW] = op_c;
    op_bus[TAP_UP*DW +: DW] = op_up;
    op_bus[TAP_DN*DW +: DW] = op_dn;
    op_bus[TAP_N*DW  +: DW] = nb_n;
    op_bus[TAP_S*DW  +: DW] = nb_s;
    op_bus[TAP_E*DW  +: DW] = nb_e;
    op_bus[TAP_W*DW  +: DW] = nb_w;
  end

  stencil_mac #(.CELLS(CELLS)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_cell (s1_cell),
    .s1_last (s1_last),
    .s1_idx  (s1_idx),
    .op_bus  (op_bus),
    .coef_bus(coef_rdata),
    .res_we  (res_we),
    .res_addr(res_addr),
    .res_data(res_data),
    .done    (done)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_re && !cell_re && !s1_cell && !$past(s1_cell) && !$past(s1_cell, 2)) |-> !res_we);
endmodule

// File: tb/tb_stencil_spmv.sv
module tb_stencil_spmv;
  localparam int  N    = 1500;
  localparam int  AW   = $clog2(N);
  localparam time TCLK = 10ns;

  logic clk, rst_n, start;
  logic signed [15:0] bnd_val;
  logic loc_re, cell_re, res_we, done;
  logic [AW-1:0] loc_addr, cell_addr, res_addr;
  logic signed [15:0] loc_q, n_q, s_q, e_q, w_q;
  logic [111:0] coef_q;
  logic signed [31:0] res_data;

  stencil_spmv #(.CELLS(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bnd_val(bnd_val),
    .loc_re(loc_re), .loc_addr(loc_addr), .loc_rdata(loc_q),
    .cell_re(cell_re), .cell_addr(cell_addr),
    .nb_n(n_q), .nb_s(s_q), .nb_e(e_q), .nb_w(w_q), .coef_rdata(coef_q),
    .res_we(res_we), .res_addr(res_addr), .res_data(res_data), .done(done)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory contents and synchronous read models
  logic signed [15:0] xm [N];
  logic signed [15:0] nm [N];
  logic signed [15:0] sm [N];
  logic signed [15:0] em [N];
  logic signed [15:0] wm [N];
  logic signed [15:0] cm [7][N];

  always @(posedge clk) begin
    if (loc_re) loc_q <= xm[loc_addr];
    if (cell_re) begin
      n_q <= nm[cell_addr];
      s_q <= sm[cell_addr];
      e_q <= em[cell_addr];
      w_q <= wm[cell_addr];
      for (int t = 0; t < 7; t++) coef_q[16*t +: 16] <= cm[t][cell_addr];
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_extra = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard queues
  int                 q_addr  [$];
  logic signed [31:0] q_data  [$];
  string              q_tag   [$];
  int                 q_first [$];

  task automatic expect_pass(string lat_tag);
    for (int i = 0; i < N; i++) begin
      longint up, dn, sum;
      string tag;
      up = (i == N-1) ? longint'(bnd_val) : 0;
      if (i != N-1) up = longint'(xm[i+1]);
      dn = (i == 0) ? longint'(bnd_val) : 0;
      if (i != 0) dn = longint'(xm[i-1]);
      sum = longint'(cm[0][i]) * longint'(xm[i]) + longint'(cm[1][i]) * up
          + longint'(cm[2][i]) * dn + longint'(cm[3][i]) * longint'(nm[i])
          + longint'(cm[4][i]) * longint'(sm[i]) + longint'(cm[5][i]) * longint'(em[i])
          + longint'(cm[6][i]) * longint'(wm[i]);
      if (i == 0)        tag = "R4";
      else if (i == N-1) tag = "R3";
      else               tag = lat_tag;
      if (sum > 64'sd2147483647) begin sum = 64'sd2147483647; tag = "R6"; end
      if (sum < -64'sd2147483648) begin sum = -64'sd2147483648; tag = "R6"; end
      q_addr.push_back(i);
      q_data.push_back(32'(sum));
      q_tag.push_back(tag);
    end
  endtask

  // mode 0: random all; 1: saturating; 2: lateral taps only; 3: vertical taps only
  task automatic fill(int mode);
    for (int i = 0; i < N; i++) begin
      xm[i] = 16'($urandom); nm[i] = 16'($urandom); sm[i] = 16'($urandom);
      em[i] = 16'($urandom); wm[i] = 16'($urandom);
      for (int t = 0; t < 7; t++) cm[t][i] = 16'($urandom);
      if (mode == 1) begin
        logic signed [15:0] v;
        v = (i < N/2) ? -16'sd32768 : 16'sd32767;
        xm[i] = v; nm[i] = v; sm[i] = v; em[i] = v; wm[i] = v;
        for (int t = 0; t < 7; t++) cm[t][i] = -16'sd32768;
      end
      if (mode == 2) for (int t = 0; t < 3; t++) cm[t][i] = '0;
      if (mode == 3) for (int t = 3; t < 7; t++) cm[t][i] = '0;
      if (mode == 3) cm[0][i] = '0;
    end
    case (mode)
      1:       bnd_val = -16'sd32768;
      3:       bnd_val = 16'sd12345;
      default: bnd_val = 16'($urandom);
    endcase
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    q_first.push_back(cyc + 4);
  endtask

  // monitor
  bit prev_we = 0;
  int prev_addr = -1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (res_we) begin
        if (q_addr.size() == 0) begin
          n_extra++;
          check(1'b0, "R9", "unexpected write addr", longint'(res_addr), -1);
        end else begin
          int ea;
          logic signed [31:0] ed;
          string et;
          ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
          check(int'(res_addr) == ea, "R1", "result address", longint'(res_addr), ea);
          check(res_data == ed, et, "result data", longint'(res_data), longint'(ed));
          if (ea == 0) begin
            int ef;
            ef = (q_first.size() != 0) ? q_first.pop_front() : -1;
            check(cyc == ef, "R7", "first write cycle", cyc, ef);
          end else begin
            check(prev_we && (prev_addr == ea - 1), "R1", "gap before write", prev_addr, ea - 1);
          end
        end
        check(!done, "R8", "done with write", done, 0);
      end
      if (done) begin
        n_done++;
        check(prev_we && (prev_addr == N-1), "R8", "done position", prev_addr, N-1);
      end else if (prev_we && prev_addr == N-1) begin
        check(1'b0, "R8", "missing done", 0, 1);
      end
      prev_we = res_we;
      prev_addr = res_we ? int'(res_addr) : -1;
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bnd_val = '0;
    repeat (3) @(negedge clk);
    check(!res_we && !done, "R10", "outputs in reset", {res_we, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!res_we && !done, "R10", "outputs idle after reset", {res_we, done}, 0);

    // random operands, all taps
    fill(0); expect_pass("R2"); pulse_start(); repeat (N + 8) @(negedge clk);
    // saturation both ways
    fill(1); expect_pass("R6"); pulse_start(); repeat (N + 8) @(negedge clk);
    // lateral taps only
    fill(2); expect_pass("R5"); pulse_start(); repeat (N + 8) @(negedge clk);
    // vertical taps only, boundary emphasis
    fill(3); expect_pass("R2"); pulse_start(); repeat (N + 8) @(negedge clk);

    // start pulses during a pass are ignored
    fill(0); expect_pass("R2"); pulse_start();
    repeat (100) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    repeat (N - 110) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    check(n_extra == 0 && q_addr.size() == 0, "R9", "extra writes after ignored start",
          n_extra, 0);
    check(n_done == 5, "R8", "done count", n_done, 5);

    // start held high: back-to-back passes overlap drain and refill
    fill(0); expect_pass("R7"); expect_pass("R9");
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    q_first.push_back(cyc + 4);
    q_first.push_back(cyc + N + 2 + 4);
    repeat (N + 5) @(negedge clk);
    start = 1'b0;
    repeat (N + 20) @(negedge clk);
    check(q_addr.size() == 0, "R9", "pending results after held start", q_addr.size(), 0);
    check(n_done == 7, "R8", "done count after held start", n_done, 7);
    check(!res_we && !done, "R10", "idle after passes", {res_we, done}, 0);
    summary();
  end
endmodule